// File: doc/BRIEF.md
# Register-Mapped Serial Port with Cascaded Rate Divider

This block is an asynchronous serial transmitter and receiver reached through a small 16-bit register bus. It sends and receives 8N1 frames. The line idles high. Each frame has one start bit, eight data bits sent least significant bit first, and one stop bit. Software writes a byte to send through either of two data addresses: one takes the byte from the low half of the bus word and the other from the high half. Software reads the last received byte from the same two addresses.

The bit period comes from the system clock through two counters in series. A prescaler divides by (D1+1), and a bit counter then divides by D2, so one bit lasts exactly (D1+1)×D2 clock cycles. The transmitter has a single holding byte in front of its shift register, which lets software queue one byte while a frame is on the line. The receiver keeps one received byte. The block gives one-cycle interrupt pulses for each byte loaded into the transmit shifter and for each byte received, plus level flags for a pending transmit byte and for unread receive data.

Register map (bus_addr): 0 = data, low byte; 1 = data, high byte; 2 = rate divider; 3 = reads as zero, writes ignored.

Top module: `uart_regbus`

## Requirements
- R1: After reset the divider reads 0x0000, txd is high, and tx_full, rx_full, tx_irq and rx_irq are low.
- R2: The divider register at address 2 reads back what was written. D1 sits in bits 15:8 and D2 in bits 7:0.
- R3: A frame on txd is one low start bit, eight data bits LSB first and one high stop bit. Each bit lasts exactly (D1+1)×D2 clock cycles, and txd stays high whenever no frame is in progress.
- R4: While D2 is below 6 (including the reset value 0), no frame starts and no byte is received. A byte written in that state waits with tx_full set and starts once D2 becomes 6 or more.
- R5: A write of a byte while the transmitter is idle, the holding register is empty and D2 ≥ 6 loads the shifter on that clock edge. In the following cycle tx_irq is high for exactly one cycle and txd shows the start bit.
- R6: A byte written while a frame is in progress sets tx_full. In the cycle right after the stop bit of the current frame ends, the held byte's start bit begins with no gap, tx_full falls and tx_irq pulses.
- R7: A write to address 0 sends bus bits 7:0, and a write to address 1 sends bus bits 15:8. The other half of the bus word has no effect on the frame.
- R8: A received frame whose stop bit is high stores its byte and gives a one-cycle rx_irq pulse, and rx_full is set in the next cycle.
- R9: A received frame whose stop bit is low is discarded: no rx_irq, and rx_full does not change.
- R10: A read at address 0 returns {8'h00, byte}, and a read at address 1 returns {byte, 8'h00}. A read at either address clears rx_full at the next edge, unless a new byte arrives on that same edge.
- R11: A new byte received while rx_full is still set replaces the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_rd | input | 1 | Read strobe (with bus_sel); a read of the data addresses clears rx_full |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_irq | output | 1 | Pulse: a byte entered the transmit shifter |
| rx_irq | output | 1 | Pulse: a valid byte was received |
| tx_full | output | 1 | Holding byte waiting to be sent |
| rx_full | output | 1 | Unread received byte present |

## Verification
The bound checker watches, on every cycle, the rules that need no knowledge of timing. txd must be high outside a frame, and nothing may start while D2 is below 6. The two interrupts must be single-cycle pulses, and a fall of tx_full must coincide with a transmit load. A receive pulse must be followed by rx_full, a data read must clear it, and the upper read byte at address 0 must be zero. The exact bit period for each (D1, D2) pair, the bit order, the release of a held byte after the stop bit, the rejection of a bad stop bit and the overwrite of an unread byte can only be shown by the bench scenarios. These scenarios decode txd at bit centres and loop every byte value back through the receiver.

// File: rtl/uart_regbus_pkg.sv
package uart_regbus_pkg;
  localparam int BUS_W      = 16;
  localparam int BYTE_W     = 8;
  localparam int DIV_W      = 8;
  localparam int FRAME_BITS = BYTE_W + 2;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0] D2_MIN = DIV_W'(6);

  typedef enum logic [1:0] {
    REG_DATA_LO = 2'd0,
    REG_DATA_HI = 2'd1,
    REG_DIVIDER = 2'd2,
    REG_NONE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/uart_bitclk.sv
module uart_bitclk #(
  parameter int CNT_W  = 8,
  parameter bit AT_MID = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] d1,
  input  logic [CNT_W-1:0] d2,
  output logic             tick
);
  logic [CNT_W-1:0] pre_q, pre_d, cyc_q, cyc_d;
  logic [CNT_W-1:0] last_cyc, target;
  logic             pre_wrap, cyc_wrap;

  assign last_cyc = d2 - CNT_W'(1);

  generate
    if (AT_MID) begin : g_mid
      assign target = (d2 >> 1) - CNT_W'(1);
    end else begin : g_end
      assign target = last_cyc;
    end
  endgenerate

  assign pre_wrap = (pre_q == d1);
  assign cyc_wrap = pre_wrap && (cyc_q == last_cyc);
  assign tick     = run && pre_wrap && (cyc_q == target);

  always_comb begin
    pre_d = pre_q;
    cyc_d = cyc_q;
    if (!run) begin
      pre_d = '0;
      cyc_d = '0;
    end else if (pre_wrap) begin
      pre_d = '0;
      cyc_d = cyc_wrap ? '0 : cyc_q + CNT_W'(1);
    end else begin
      pre_d = pre_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cyc_q <= '0;
    end else begin
      pre_q <= pre_d;
      cyc_q <= cyc_d;
    end
  end
endmodule

// File: rtl/uart_txpath.sv
module uart_txpath
  import uart_regbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              bit_tick,
  output logic              busy,
  output logic              txd,
  output logic              load_pulse,
  output logic              hold_full
);
  logic                  busy_q, busy_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [BYTE_W-1:0]     hold_q, hold_d;
  logic                  full_q, full_d;
  logic                  irq_q, irq_d;
  logic                  frame_end, direct, from_hold;

  assign frame_end = busy_q && bit_tick && (idx_q == IDX_W'(FRAME_BITS-1));
  assign direct    = wr_stb && en && !busy_q && !full_q;
  assign from_hold = full_q && en && (!busy_q || frame_end);

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    hold_d = hold_q;
    full_d = full_q;
    irq_d  = 1'b0;
    if (busy_q && bit_tick) begin
      if (frame_end) begin
        busy_d = 1'b0;
      end else begin
        sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
        idx_d = idx_q + IDX_W'(1);
      end
    end
    if (direct) begin
      busy_d = 1'b1;
      sh_d   = {1'b1, wr_byte, 1'b0};
      idx_d  = '0;
      irq_d  = 1'b1;
    end else if (from_hold) begin
      busy_d = 1'b1;
      sh_d   = {1'b1, hold_q, 1'b0};
      idx_d  = '0;
      irq_d  = 1'b1;
      full_d = 1'b0;
    end
    if (wr_stb && !direct) begin
      hold_d = wr_byte;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      hold_q <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      hold_q <= hold_d;
      full_q <= full_d;
      irq_q  <= irq_d;
    end
  end

  assign busy       = busy_q;
  assign txd        = busy_q ? sh_q[0] : 1'b1;
  assign load_pulse = irq_q;
  assign hold_full  = full_q;
endmodule

// File: rtl/uart_rxpath.sv
module uart_rxpath
  import uart_regbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rxd,
  input  logic              mid_tick,
  output logic              run,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_out
);
  logic              s1_q, s2_q, prev_q, fall;
  logic              act_q, act_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] sh_q, sh_d, byte_q, byte_d;
  logic              vld_q, vld_d;

  assign fall = prev_q && !s2_q;

  always_comb begin
    act_d  = act_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    byte_d = byte_q;
    vld_d  = 1'b0;
    if (!act_q) begin
      if (en && fall) begin
        act_d = 1'b1;
        idx_d = '0;
      end
    end else if (!en) begin
      act_d = 1'b0;
    end else if (mid_tick) begin
      idx_d = idx_q + IDX_W'(1);
      if (idx_q == '0) begin
        if (s2_q) act_d = 1'b0;
      end else if (idx_q == IDX_W'(FRAME_BITS-1)) begin
        act_d = 1'b0;
        if (s2_q) begin
          vld_d  = 1'b1;
          byte_d = sh_q;
        end
      end else begin
        sh_d = {s2_q, sh_q[BYTE_W-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      act_q  <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      act_q  <= act_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
    end
  end

  assign run      = act_q;
  assign byte_vld = vld_q;
  assign byte_out = byte_q;
endmodule

// File: rtl/uart_regbus.sv
module uart_regbus
  import uart_regbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             rxd,
  output logic             txd,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic             tx_full,
  output logic             rx_full
);
  logic              rst_meta_n, rst_sync_n;
  logic [BUS_W-1:0]  div_q, div_d;
  logic [BYTE_W-1:0] rx_data_q, rx_data_d;
  logic              rx_full_q, rx_full_d;
  logic [DIV_W-1:0]  d1, d2;
  logic              rate_ok, data_wr, data_rd, div_wr;
  logic [BYTE_W-1:0] wr_byte;
  logic              tx_busy, tx_tick, rx_run, rx_tick, rx_vld;
  logic [BYTE_W-1:0] rx_byte;
  reg_sel_e          sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign sel     = reg_sel_e'(bus_addr);
  assign d1      = div_q[BUS_W-1:BUS_W-DIV_W];
  assign d2      = div_q[DIV_W-1:0];
  assign rate_ok = (d2 >= D2_MIN);
  assign data_wr = bus_sel && bus_wr && ((sel == REG_DATA_LO) || (sel == REG_DATA_HI));
  assign data_rd = bus_sel && bus_rd && ((sel == REG_DATA_LO) || (sel == REG_DATA_HI));
  assign div_wr  = bus_sel && bus_wr && (sel == REG_DIVIDER);
  assign wr_byte = (sel == REG_DATA_HI) ? bus_wdata[BUS_W-1:BUS_W-BYTE_W] : bus_wdata[BYTE_W-1:0];

  always_comb begin
    div_d     = div_wr ? bus_wdata : div_q;
    rx_data_d = rx_vld ? rx_byte : rx_data_q;
    rx_full_d = rx_full_q;
    if (rx_vld)       rx_full_d = 1'b1;
    else if (data_rd) rx_full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      div_q     <= '0;
      rx_data_q <= '0;
      rx_full_q <= 1'b0;
    end else begin
      div_q     <= div_d;
      rx_data_q <= rx_data_d;
      rx_full_q <= rx_full_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      REG_DATA_LO: bus_rdata = {{(BUS_W-BYTE_W){1'b0}}, rx_data_q};
      REG_DATA_HI: bus_rdata = {rx_data_q, {(BUS_W-BYTE_W){1'b0}}};
      REG_DIVIDER: bus_rdata = div_q;
      default:     bus_rdata = '0;
    endcase
  end

  uart_bitclk #(.CNT_W(DIV_W), .AT_MID(1'b0)) u_tx_rate (
    .clk(clk), .rst_n(rst_sync_n), .run(tx_busy), .d1(d1), .d2(d2), .tick(tx_tick)
  );

  uart_bitclk #(.CNT_W(DIV_W), .AT_MID(1'b1)) u_rx_rate (
    .clk(clk), .rst_n(rst_sync_n), .run(rx_run), .d1(d1), .d2(d2), .tick(rx_tick)
  );

  uart_txpath u_tx (
    .clk(clk), .rst_n(rst_sync_n), .en(rate_ok), .wr_stb(data_wr), .wr_byte(wr_byte),
    .bit_tick(tx_tick), .busy(tx_busy), .txd(txd), .load_pulse(tx_irq), .hold_full(tx_full)
  );

  uart_rxpath u_rx (
    .clk(clk), .rst_n(rst_sync_n), .en(rate_ok), .rxd(rxd), .mid_tick(rx_tick),
    .run(rx_run), .byte_vld(rx_vld), .byte_out(rx_byte)
  );

  assign rx_irq  = rx_vld;
  assign rx_full = rx_full_q;
endmodule

// File: rtl/uart_regbus_chk.sv
module uart_regbus_chk
  import uart_regbus_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_rd,
  input logic [1:0]       bus_addr,
  input logic [BUS_W-1:0] bus_rdata,
  input logic             txd,
  input logic             tx_irq,
  input logic             tx_full,
  input logic             rx_irq,
  input logic             rx_full,
  input logic             tx_busy,
  input logic [BUS_W-1:0] div_q
);
  logic data_read;
  assign data_read = bus_sel && bus_rd && (bus_addr <= 2'd1);

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  assert_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && (div_q[DIV_W-1:0] < D2_MIN)) |=> !tx_busy);

  assert_tx_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  assert_hold_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_full) |-> tx_irq);

  assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> (rx_full && !rx_irq));

  assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_read && !rx_irq) |=> !rx_full);

  assert_low_read_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[BUS_W-1:BYTE_W] == '0));
endmodule

bind uart_regbus uart_regbus_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .txd(txd), .tx_irq(tx_irq), .tx_full(tx_full), .rx_irq(rx_irq),
  .rx_full(rx_full), .tx_busy(tx_busy), .div_q(div_q)
);

// File: tb/sim_uart_regbus.sv
module sim_uart_regbus;
  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk, rst_n, bus_sel, bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        rxd, txd, tx_irq, rx_irq, tx_full, rx_full;
  logic        loop_en, drv_rxd;
  int          checks, failures, rx_irq_cnt;

  assign rxd = loop_en ? txd : drv_rxd;

  uart_regbus u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd),
    .txd(txd), .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_full(tx_full), .rx_full(rx_full)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial rx_irq_cnt = 0;
  always @(posedge clk) if (rx_irq) rx_irq_cnt <= rx_irq_cnt + 1;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0; bus_addr = 2'd3;
  endtask

  // Current negedge is cycle 'elapsed' of a frame whose start bit began at cycle 0.
  task automatic tx_expect(input logic [7:0] b, input int p, input int elapsed, input string req);
    int cur = elapsed;
    for (int i = 0; i < 10; i++) begin
      int tgt = i * p + p / 2;
      logic e;
      repeat (tgt - cur) @(negedge clk);
      cur = tgt;
      e = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
      chk(req, $sformatf("txd bit %0d of %h p=%0d", i, b, p), {15'd0, txd}, {15'd0, e});
    end
    repeat (10 * p - cur) @(negedge clk);
  endtask

  task automatic wait_tx_start(input int limit, output bit found);
    found = 1'b0;
    for (int n = 0; n < limit; n++) begin
      if (tx_irq) begin found = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop, input int p);
    for (int i = 0; i < 10; i++) begin
      drv_rxd = (i == 0) ? 1'b0 : (i == 9) ? stop : b[i-1];
      repeat (p) @(negedge clk);
    end
    drv_rxd = 1'b1;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rd;
    bit          found;
    bit          low_seen;
    int          base;
    checks = 0; failures = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = 2'd3; bus_wdata = '0; loop_en = 1'b0; drv_rxd = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "txd", {15'd0, txd}, 16'd1);
    chk("R1", "tx_full", {15'd0, tx_full}, 16'd0);
    chk("R1", "rx_full", {15'd0, rx_full}, 16'd0);
    chk("R1", "irqs", {14'd0, tx_irq, rx_irq}, 16'd0);
    bus_read(2'd2, rd);
    chk("R1", "divider reset", rd, 16'h0000);

    // R4 divider at zero: byte waits, line quiet, receiver deaf
    bus_write(2'd0, 16'h00A5);
    chk("R4", "tx_full with D2=0", {15'd0, tx_full}, 16'd1);
    low_seen = 1'b0;
    for (int n = 0; n < 80; n++) begin
      if (!txd || tx_irq) low_seen = 1'b1;
      @(negedge clk);
    end
    chk("R4", "no start D2=0", {15'd0, low_seen}, 16'd0);
    base = rx_irq_cnt;
    send_frame(8'h3C, 1'b1, 20);
    repeat (20) @(negedge clk);
    chk("R4", "no rx D2=0", rx_irq_cnt - base, 0);
    chk("R4", "rx_full D2=0", {15'd0, rx_full}, 16'd0);
    bus_write(2'd2, 16'h0005);
    low_seen = 1'b0;
    for (int n = 0; n < 60; n++) begin
      if (!txd || tx_irq) low_seen = 1'b1;
      @(negedge clk);
    end
    chk("R4", "no start D2=5", {15'd0, low_seen}, 16'd0);
    bus_write(2'd2, 16'h0006);
    wait_tx_start(10, found);
    chk("R4", "start after D2=6", {15'd0, found}, 16'd1);
    tx_expect(8'hA5, 6, 0, "R4");
    chk("R4", "tx_full cleared", {15'd0, tx_full}, 16'd0);

    // R2 divider readback
    bus_write(2'd2, 16'h2A3F);
    bus_read(2'd2, rd);
    chk("R2", "div readback", rd, 16'h2A3F);
    bus_write(2'd2, 16'hFF06);
    bus_read(2'd2, rd);
    chk("R2", "div readback", rd, 16'hFF06);

    // Loopback sweep of every byte value at D1=0, D2=6
    bus_write(2'd2, 16'h0006);
    loop_en = 1'b1;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b = 8'(v);
      base = rx_irq_cnt;
      if (v[0]) bus_write(2'd1, {b, ~b});
      else      bus_write(2'd0, {~b, b});
      chk("R5", "tx_irq after idle write", {15'd0, tx_irq}, 16'd1);
      chk("R5", "start bit after idle write", {15'd0, txd}, 16'd0);
      chk("R7", "no hold on idle write", {15'd0, tx_full}, 16'd0);
      tx_expect(b, 6, 0, v[0] ? "R7" : "R3");
      repeat (8) @(negedge clk);
      chk("R8", "rx_full after frame", {15'd0, rx_full}, 16'd1);
      chk("R8", "one rx_irq", rx_irq_cnt - base, 1);
      bus_read(v[0] ? 2'd1 : 2'd0, rd);
      chk("R10", "read data", rd, v[0] ? {b, 8'h00} : {8'h00, b});
      chk("R10", "rx_full cleared by read", {15'd0, rx_full}, 16'd0);
    end

    // Rate sweep with back-to-back bytes
    for (int i1 = 0; i1 < 3; i1++) begin
      for (int i2 = 0; i2 < 3; i2++) begin
        int d1 = (i1 == 2) ? 3 : i1;
        int d2 = (i2 == 0) ? 6 : (i2 == 1) ? 7 : 10;
        int p  = (d1 + 1) * d2;
        logic [7:0] b1 = 8'h5A ^ 8'(d1 * 16 + d2);
        logic [7:0] b2 = ~b1;
        bus_write(2'd2, {8'(d1), 8'(d2)});
        base = rx_irq_cnt;
        bus_write(2'd0, {8'hFF, b1});
        chk("R5", "tx_irq rate sweep", {15'd0, tx_irq}, 16'd1);
        bus_write(2'd0, {8'h00, b2});
        chk("R6", "tx_full on busy write", {15'd0, tx_full}, 16'd1);
        tx_expect(b1, p, 2, "R3");
        chk("R6", "tx_irq at release", {15'd0, tx_irq}, 16'd1);
        chk("R6", "tx_full cleared at release", {15'd0, tx_full}, 16'd0);
        chk("R6", "no gap start bit", {15'd0, txd}, 16'd0);
        tx_expect(b2, p, 0, "R3");
        repeat (4 * p) @(negedge clk);
        chk("R11", "two bytes received", rx_irq_cnt - base, 2);
        bus_read(2'd0, rd);
        chk("R11", "second byte overwrote first", rd, {8'h00, b2});
      end
    end

    // R9 bad stop bit, then a good frame
    loop_en = 1'b0;
    bus_write(2'd2, 16'h0108);
    repeat (10) @(negedge clk);
    base = rx_irq_cnt;
    send_frame(8'h81, 1'b0, 16);
    repeat (48) @(negedge clk);
    chk("R9", "no rx_irq on bad stop", rx_irq_cnt - base, 0);
    chk("R9", "rx_full unchanged", {15'd0, rx_full}, 16'd0);
    send_frame(8'hC3, 1'b1, 16);
    repeat (32) @(negedge clk);
    chk("R8", "good frame after bad", rx_irq_cnt - base, 1);
    chk("R8", "rx_full set", {15'd0, rx_full}, 16'd1);
    bus_read(2'd1, rd);
    chk("R10", "high read", rd, 16'hC300);
    chk("R10", "rx_full cleared", {15'd0, rx_full}, 16'd0);

    summary();
    $finish;
  end
endmodule